// File: doc/BRIEF.md
# Saturating Vector Element Clamp Unit

This unit walks through a vector of wide integer intermediate results, one element per clock. Each element is clamped to the range of a chosen destination element width of 8, 16 or 32 bits. The range is either unsigned or signed. A pulse on `start` captures the whole configuration: vector length, width code, signedness, record enable and a carry-operation flag. The unit then reads element `i` through `rd_idx`/`rd_data` and emits the clamped value on a registered write port.

When record mode is on, every element also gets its own 4-bit condition field. The field holds lt, gt and eq bits for the clamped value, plus an overflow bit. The overflow bit says only whether that one element was clamped. No flag accumulates across elements or across vectors.

Saturation is refused for operations that also produce a carry, because the carry would need the same condition bit. Such a request completes at once with `reject` raised and nothing written.

Top module: `sat_vec_unit`

## Requirements
- R1: The cycle after `start` is sampled high while idle, the unit captures the configuration. It then reads elements 0..VL-1 on `rd_idx`, one per cycle. Each element appears on `wr_en`/`wr_idx`/`wr_data` one cycle after its read, with indices ascending by one. `done` pulses together with the write of element VL-1.
- R2: A vector length of 0 produces a `done` pulse one cycle after `start`, with no write of any kind.
- R3: When `cfg_signed`=0, the intermediate value is read as a two's-complement `rd_data`. Values below 0 become 0, values above 2^w-1 become 2^w-1, and the result is zero-extended on `wr_data`.
- R4: When `cfg_signed`=1, values are clamped to the range -2^(w-1) to 2^(w-1)-1, and the result is sign-extended on `wr_data`.
- R5: `cfg_ew` selects the width w: 2'b00 is 8 bits, 2'b01 is 16 bits, and 2'b10 or 2'b11 is 32 bits.
- R6: Bit 0 of `cr_field` is 1 exactly when that element was clamped. It depends on no other element and on no earlier vector.
- R7: Bits 3, 2 and 1 of `cr_field` are lt, gt and eq of the clamped value. The compare is signed when `cfg_signed`=1 and unsigned otherwise, so lt is always 0 in unsigned mode. Exactly one of the three bits is set.
- R8: With `cfg_rec`=1, `cr_we` is high with every element write. With `cfg_rec`=0, `cr_we` stays low.
- R9: A `start` with `cfg_carry`=1 pulses `done` and `reject` one cycle later and writes nothing. `reject` is never high without `done`.
- R10: `start` is ignored while `busy` is high. The run in progress keeps its captured length and mode.
- R11: After reset, `busy`, `wr_en`, `cr_we`, `done` and `reject` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a vector, sampled while idle |
| cfg_vl | input | VL_W | Vector length |
| cfg_ew | input | 2 | Destination width code |
| cfg_signed | input | 1 | 1 selects a signed range |
| cfg_rec | input | 1 | Record enable for condition fields |
| cfg_carry | input | 1 | Operation produces a carry, so the request is refused |
| busy | output | 1 | Vector in progress |
| rd_idx | output | VL_W | Index of the element being read |
| rd_data | input | SRC_W | Wide intermediate for `rd_idx`, two's complement |
| wr_en | output | 1 | Clamped element valid |
| wr_idx | output | VL_W | Index of the written element |
| wr_data | output | 32 | Clamped element, extended per mode |
| cr_we | output | 1 | Condition field valid |
| cr_field | output | 4 | {lt, gt, eq, overflow} |
| done | output | 1 | Vector finished |
| reject | output | 1 | Request refused because of carry |

## Verification
The bench drives values sitting exactly on each range boundary and one step past it, in both modes and for every width code. A unit with an off-by-one bound or a wrong sign extension would therefore show a wrong value or a wrong overflow bit. Vectors that saturate are placed right before vectors that do not, so an overflow bit that stuck across elements or runs would be caught. A length of zero, the carry refusal, record mode off, and a start arriving mid-run are each covered. A unit that wrote a spurious element, or that took up the new length, would show a write or a `done` in a cycle where none belongs.

// File: rtl/sat_vec_unit.sv
module sat_vec_unit #(
  parameter int SRC_W = 64,
  parameter int VL_W  = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [VL_W-1:0]  cfg_vl,
  input  logic [1:0]       cfg_ew,
  input  logic             cfg_signed,
  input  logic             cfg_rec,
  input  logic             cfg_carry,
  output logic             busy,
  output logic [VL_W-1:0]  rd_idx,
  input  logic [SRC_W-1:0] rd_data,
  output logic             wr_en,
  output logic [VL_W-1:0]  wr_idx,
  output logic [31:0]      wr_data,
  output logic             cr_we,
  output logic [3:0]       cr_field,
  output logic             done,
  output logic             reject
);
  localparam int DST_W = 32;
  localparam logic [SRC_W-1:0] ONE = SRC_W'(1);

  logic [VL_W-1:0] vl_q, idx;
  logic [1:0]      ew_q;
  logic            sgn_q, rec_q;

  int                      wbits;
  logic signed [SRC_W-1:0] x, hi, lo, y;
  logic                    sat, lt, gt, eq;

  assign rd_idx = idx;
  assign x = rd_data;

  always_comb begin
    case (ew_q)
      2'b00:   wbits = 8;
      2'b01:   wbits = 16;
      default: wbits = DST_W;
    endcase
    if (sgn_q) begin
      hi = (ONE << (wbits - 1)) - ONE;
      lo = -(ONE << (wbits - 1));
    end else begin
      hi = (ONE << wbits) - ONE;
      lo = '0;
    end
    if (x > hi) begin
      y = hi; sat = 1'b1;
    end else if (x < lo) begin
      y = lo; sat = 1'b1;
    end else begin
      y = x; sat = 1'b0;
    end
  end

  assign lt = (y < 0);
  assign gt = (y > 0);
  assign eq = (y == 0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      idx      <= '0;
      vl_q     <= '0;
      ew_q     <= 2'b00;
      sgn_q    <= 1'b0;
      rec_q    <= 1'b0;
      wr_en    <= 1'b0;
      wr_idx   <= '0;
      wr_data  <= '0;
      cr_we    <= 1'b0;
      cr_field <= '0;
      done     <= 1'b0;
      reject   <= 1'b0;
    end else begin
      wr_en  <= 1'b0;
      cr_we  <= 1'b0;
      done   <= 1'b0;
      reject <= 1'b0;
      if (!busy && start) begin
        vl_q  <= cfg_vl;
        ew_q  <= cfg_ew;
        sgn_q <= cfg_signed;
        rec_q <= cfg_rec;
        idx   <= '0;
        if (cfg_carry || cfg_vl == '0) begin
          done   <= 1'b1;
          reject <= cfg_carry;
        end else begin
          busy <= 1'b1;
        end
      end else if (busy) begin
        wr_en    <= 1'b1;
        wr_idx   <= idx;
        wr_data  <= y[DST_W-1:0];
        cr_we    <= rec_q;
        cr_field <= {lt, gt, eq, sat};
        idx      <= idx + VL_W'(1);
        if (idx == vl_q - VL_W'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sat_vec_unit_chk.sv
module sat_vec_unit_chk #(
  parameter int VL_W = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            busy,
  input logic            wr_en,
  input logic [VL_W-1:0] wr_idx,
  input logic [31:0]     wr_data,
  input logic            cr_we,
  input logic [3:0]      cr_field,
  input logic            done,
  input logic            reject
);
  assert_idx_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !done) |=> (wr_en && wr_idx == $past(wr_idx) + VL_W'(1)));

  assert_quiet_after_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !wr_en);

  assert_eq_means_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cr_we && cr_field[1]) |-> (wr_data == 32'd0));

  assert_one_relation_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cr_we |-> ($countones(cr_field[3:1]) == 1));

  assert_cr_with_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cr_we |-> wr_en);

  assert_reject_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    reject |-> (done && !wr_en));

  assert_busy_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !done) |=> (busy || done));
endmodule

bind sat_vec_unit sat_vec_unit_chk #(.VL_W(VL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .wr_en(wr_en),
  .wr_idx(wr_idx), .wr_data(wr_data), .cr_we(cr_we), .cr_field(cr_field),
  .done(done), .reject(reject)
);

// File: tb/sat_vec_unit_tb.sv
`timescale 1ns/1ps
module sat_vec_unit_tb;
  localparam int SRC_W = 64;
  localparam int VL_W  = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [VL_W-1:0] cfg_vl = '0;
  logic [1:0] cfg_ew = 2'b00;
  logic cfg_signed = 1'b0, cfg_rec = 1'b0, cfg_carry = 1'b0;
  logic busy, wr_en, cr_we, done, reject;
  logic [VL_W-1:0] rd_idx, wr_idx;
  logic [SRC_W-1:0] rd_data;
  logic [31:0] wr_data;
  logic [3:0] cr_field;

  longint mem [128];
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;
  always_comb rd_data = mem[rd_idx];

  sat_vec_unit #(.SRC_W(SRC_W), .VL_W(VL_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_vl(cfg_vl), .cfg_ew(cfg_ew),
    .cfg_signed(cfg_signed), .cfg_rec(cfg_rec), .cfg_carry(cfg_carry),
    .busy(busy), .rd_idx(rd_idx), .rd_data(rd_data), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_data(wr_data), .cr_we(cr_we), .cr_field(cr_field),
    .done(done), .reject(reject)
  );

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic longint model(longint v, int code, bit s, output bit ov);
    int w;
    longint hi, lo, r;
    w = (code == 0) ? 8 : (code == 1) ? 16 : 32;
    hi = s ? (64'sd1 <<< (w - 1)) - 1 : (64'sd1 <<< w) - 1;
    lo = s ? -(64'sd1 <<< (w - 1)) : 0;
    ov = 1'b1;
    if (v > hi) r = hi;
    else if (v < lo) r = lo;
    else begin r = v; ov = 1'b0; end
    return r;
  endfunction

  task automatic expect_idle(string req);
    chk(wr_en == 0, req, "wr_en idle", longint'(wr_en), 0);
    chk(cr_we == 0, req, "cr_we idle", longint'(cr_we), 0);
    chk(done == 0, req, "done idle", longint'(done), 0);
  endtask

  task automatic run(int vl, int code, bit s, bit rec, bit carry, bit poke);
    bit ov;
    longint r;
    @(negedge clk);
    cfg_vl = VL_W'(vl); cfg_ew = 2'(code); cfg_signed = s;
    cfg_rec = rec; cfg_carry = carry; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (carry || vl == 0) begin
      chk(done == 1, carry ? "R9" : "R2", "done", longint'(done), 1);
      chk(reject == carry, "R9", "reject", longint'(reject), longint'(carry));
      chk(wr_en == 0, carry ? "R9" : "R2", "no write", longint'(wr_en), 0);
      @(negedge clk);
      expect_idle(carry ? "R9" : "R2");
      return;
    end
    chk(busy == 1 && wr_en == 0 && done == 0, "R1", "first cycle", longint'(wr_en), 0);
    for (int k = 0; k < vl; k++) begin
      if (poke && k == 0) begin
        cfg_vl = VL_W'(2); cfg_ew = 2'b00; cfg_signed = ~s; cfg_rec = ~rec; start = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
      r = model(mem[k], code, s, ov);
      chk(wr_en == 1, poke ? "R10" : "R1", "wr_en", longint'(wr_en), 1);
      chk(wr_idx == VL_W'(k), "R1", "wr_idx", longint'(wr_idx), k);
      chk(wr_data == r[31:0], s ? "R4" : "R3", "wr_data", longint'(wr_data), longint'(r[31:0]));
      chk(cr_we == rec, "R8", "cr_we", longint'(cr_we), longint'(rec));
      chk(done == (k == vl - 1), poke ? "R10" : "R1", "done", longint'(done), longint'(k == vl - 1));
      if (rec) begin
        chk(cr_field[0] == ov, "R6", "overflow bit", longint'(cr_field[0]), longint'(ov));
        chk(cr_field[3:1] == {r < 0, r > 0, r == 0}, "R7", "lt/gt/eq",
            longint'(cr_field[3:1]), longint'({r < 0, r > 0, r == 0}));
      end
    end
    @(negedge clk);
    expect_idle("R1");
    chk(busy == 0, "R1", "busy end", longint'(busy), 0);
  endtask

  initial begin
    #800000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = 0;
    #1;
    chk(busy == 0 && wr_en == 0 && cr_we == 0 && done == 0 && reject == 0,
        "R11", "reset outputs", longint'({busy, wr_en, cr_we, done, reject}), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R3 R5: unsigned 8-bit boundaries
    mem[0] = 0; mem[1] = 255; mem[2] = 256; mem[3] = -1; mem[4] = 100; mem[5] = 1000;
    run(6, 0, 1'b0, 1'b1, 1'b0, 1'b0);
    // R4 R5: signed 16-bit boundaries
    mem[0] = 32767; mem[1] = 32768; mem[2] = -32768; mem[3] = -32769; mem[4] = 0; mem[5] = -5;
    run(6, 1, 1'b1, 1'b1, 1'b0, 1'b0);
    // R6: no carry-over of overflow between vectors
    mem[0] = 7; mem[1] = 0; mem[2] = -3;
    run(3, 1, 1'b1, 1'b1, 1'b0, 1'b0);
    // R3 R5: unsigned 32-bit
    mem[0] = 64'sd4294967295; mem[1] = 64'sd4294967296; mem[2] = -7; mem[3] = 64'sh7fffffffffffffff;
    run(4, 2, 1'b0, 1'b1, 1'b0, 1'b0);
    // R4 R5: signed 32-bit via code 11
    mem[0] = 64'sd2147483648; mem[1] = -64'sd2147483649; mem[2] = 12; mem[3] = -64'sd2147483648;
    run(4, 3, 1'b1, 1'b1, 1'b0, 1'b0);
    run(4, 2, 1'b1, 1'b1, 1'b0, 1'b0);
    // R8: record off
    run(4, 0, 1'b1, 1'b0, 1'b0, 1'b0);
    // R2: zero length
    run(0, 0, 1'b0, 1'b1, 1'b0, 1'b0);
    // R9: carry refused
    run(5, 0, 1'b0, 1'b1, 1'b1, 1'b0);
    // R10: start during run ignored
    mem[0] = 300; mem[1] = -300; mem[2] = 5; mem[3] = 128; mem[4] = -129;
    run(5, 0, 1'b1, 1'b1, 1'b0, 1'b1);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule